// File: doc/BRIEF.md
# Flash Sector Fetch Access Guard

This block sits between an AHB-Lite interconnect and a flash array slave. It checks every transfer against a 32-bit per-sector permission word. It uses the transfer address to find the 256 KB sector being targeted. It uses the lowest protection bit to tell an instruction fetch from a data access. A fetch aimed at a sector whose permission bit is clear is never forwarded to the flash. The guard answers it with the two-cycle AHB error response instead. All other transfers pass through untouched, and the flash's own ready and response signals are returned to the master.

The permission word is a software-visible register at offset 0x2C of a small register port. During reset it is loaded from a configuration word that stands in for a non-volatile shadow location. An erased shadow reads all ones, so every sector then allows both access kinds.

Top module: `flash_fetch_guard`

## Requirements
- R1: While `hresetn` is low, the permission word is loaded from `shadow_word` on every rising clock edge. After reset it holds the last value sampled, and an all-ones value lets fetches reach every sector.
- R2: A register write with `reg_sel=1`, `reg_write=1` and `reg_addr=0x2C` replaces the permission word with `reg_wdata`. While `reg_sel=1`, `reg_rdata` returns the word at offset 0x2C and returns zero at any other offset. Writes to any other offset leave the word unchanged.
- R3: Sector decode applies only when `haddr[31:22]` is zero. Segment s is `haddr[21:18]`. Segments 0 to 12 are governed by permission bit s. Segments 13, 14 and 15 (starting at 0x34_0000, 0x38_0000 and 0x3C_0000) are governed by bits 28, 29 and 30.
- R4: An address phase is a cycle with `hsel=1`, `htrans[1]=1` and `hready=1`. If such a phase is a fetch (`hprot[0]=0`) to a sector whose bit is 0, the guard answers with `hreadyout=0, hresp=1` in the next cycle and `hreadyout=1, hresp=1` in the cycle after that.
- R5: A blocked fetch is not forwarded: `flash_hsel` is 0 during its address phase. A transfer that passes keeps `flash_hsel` equal to `hsel`.
- R6: A data access (`hprot[0]=1`) always passes, whatever the sector's bit. Its data phase returns `flash_hreadyout` and `flash_hresp`.
- R7: A fetch to a sector whose bit is 1 passes, and the flash's response is returned.
- R8: A transfer with a nonzero `haddr[31:22]` lies outside every sector and passes without a check.
- R9: A register write clocked on the same edge as an address phase does not affect that phase; it governs phases starting from the next cycle. Bits 13 to 27 and bit 31 govern no sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select for the flash |
| haddr | input | 32 | Transfer address |
| htrans | input | 2 | Transfer type |
| hprot | input | 4 | Protection; bit 0 is 0 for a fetch and 1 for data |
| hready | input | 1 | Bus ready (previous transfer complete) |
| hreadyout | output | 1 | Ready returned to the master |
| hresp | output | 1 | Response returned to the master, 1 for error |
| flash_hsel | output | 1 | Select forwarded to the flash |
| flash_hreadyout | input | 1 | Ready from the flash |
| flash_hresp | input | 1 | Response from the flash |
| reg_sel | input | 1 | Register port select |
| reg_write | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| shadow_word | input | 32 | Reset value of the permission word |

## Verification
The assertions assume a well-behaved bus. The flash holds its ready low for one cycle only when it issues its own error, and `hready` is fed back from `hreadyout`, so no new address phase is accepted in the first error cycle. The bench keeps within this. It ties the flash model to zero-wait OKAY, routes `hready` from the guard's own output, and holds each address phase until ready is sampled high. Register writes are issued only outside reset, including one that shares its edge with a blocked fetch.

// File: rtl/flash_fetch_guard.sv
module flash_fetch_guard #(
  parameter int WIN_LOG2     = 22,
  parameter int SECTOR_LOG2  = 18,
  parameter int LOW_SECTORS  = 13,
  parameter int HIGH_SECTORS = 3,
  parameter int HIGH_BIT     = 28,
  parameter logic [7:0] REG_OFFSET = 8'h2C
) (
  input  logic        hclk,
  input  logic        hresetn,
  input  logic        hsel,
  input  logic [31:0] haddr,
  input  logic [1:0]  htrans,
  input  logic [3:0]  hprot,
  input  logic        hready,
  output logic        hreadyout,
  output logic        hresp,
  output logic        flash_hsel,
  input  logic        flash_hreadyout,
  input  logic        flash_hresp,
  input  logic        reg_sel,
  input  logic        reg_write,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] shadow_word
);
  localparam int SEG_W = WIN_LOG2 - SECTOR_LOG2;

  logic [31:0]      perm;
  logic             err1, err2;
  logic             mapped;
  logic [4:0]       bitsel;
  logic [SEG_W-1:0] seg;

  wire unused_bits = &{1'b0, hprot[3:1], htrans[0], haddr[SECTOR_LOG2-1:0]};

  assign seg = haddr[WIN_LOG2-1:SECTOR_LOG2];
  wire in_win     = ~|haddr[31:WIN_LOG2];
  wire addr_phase = hsel & htrans[1] & hready;
  wire reg_hit    = reg_sel & (reg_addr == REG_OFFSET);

  always_comb begin
    mapped = 1'b0;
    bitsel = '0;
    if (int'(seg) < LOW_SECTORS) begin
      mapped = in_win;
      bitsel = 5'(int'(seg));
    end else if (int'(seg) < LOW_SECTORS + HIGH_SECTORS) begin
      mapped = in_win;
      bitsel = 5'(HIGH_BIT + int'(seg) - LOW_SECTORS);
    end
  end

  wire block = addr_phase & ~hprot[0] & mapped & ~perm[bitsel];

  assign flash_hsel = hsel & ~block;
  assign hreadyout  = err1 ? 1'b0 : (err2 ? 1'b1 : flash_hreadyout);
  assign hresp      = (err1 | err2) ? 1'b1 : flash_hresp;
  assign reg_rdata  = reg_hit ? perm : '0;

  always_ff @(posedge hclk) begin
    if (!hresetn)
      perm <= shadow_word;
    else if (reg_hit && reg_write)
      perm <= reg_wdata;
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      err1 <= 1'b0;
      err2 <= 1'b0;
    end else begin
      err1 <= block;
      err2 <= err1;
    end
  end

  assert_reg_write_R2: assert property (@(posedge hclk) disable iff (!hresetn)
    (reg_hit && reg_write) |=> (perm == $past(reg_wdata)));

  assert_err_first_R4: assert property (@(posedge hclk) disable iff (!hresetn)
    (addr_phase && !hprot[0] && in_win && !perm[bitsel] && mapped) |=> (!hreadyout && hresp));

  assert_err_second_R4: assert property (@(posedge hclk) disable iff (!hresetn)
    (!hreadyout && hresp) |=> (hreadyout && hresp));

  assert_no_forward_R5: assert property (@(posedge hclk) disable iff (!hresetn)
    (hsel && htrans[1] && hready && !hprot[0] && mapped && !perm[bitsel]) |-> !flash_hsel);

  assert_data_pass_R6: assert property (@(posedge hclk) disable iff (!hresetn)
    (addr_phase && hprot[0]) |=> (hresp == flash_hresp && hreadyout == flash_hreadyout));

  assert_outside_pass_R8: assert property (@(posedge hclk) disable iff (!hresetn)
    (addr_phase && !in_win) |-> flash_hsel);
endmodule

// File: tb/flash_fetch_guard_tb.sv
`timescale 1ns/1ps
module flash_fetch_guard_tb;
  logic        clk = 0, hresetn = 0;
  logic        hsel = 0;
  logic [31:0] haddr = 0;
  logic [1:0]  htrans = 0;
  logic [3:0]  hprot = 0;
  logic        hreadyout, hresp, flash_hsel;
  logic        reg_sel = 0, reg_write = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, shadow_word = 0;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  flash_fetch_guard u_dut (
    .hclk(clk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hprot(hprot), .hready(hreadyout), .hreadyout(hreadyout), .hresp(hresp),
    .flash_hsel(flash_hsel), .flash_hreadyout(1'b1), .flash_hresp(1'b0),
    .reg_sel(reg_sel), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .shadow_word(shadow_word));

  bit    qerr[$];
  string qtag[$];
  bit    pend = 0, perr = 0, pphase = 0;
  string ptag;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (hresetn) begin
    if (pend) begin
      if (perr && !pphase) begin
        chk(!hreadyout && hresp, {ptag, " err cycle1"}, {30'd0, hreadyout, hresp}, 32'd1);
        pphase = 1;
      end else if (perr) begin
        chk(hreadyout && hresp, {ptag, " err cycle2"}, {30'd0, hreadyout, hresp}, 32'd3);
        pend = 0;
      end else begin
        chk(hreadyout && !hresp, {ptag, " okay"}, {30'd0, hreadyout, hresp}, 32'd2);
        pend = 0;
      end
    end
    if (hsel && htrans[1] && hreadyout) begin
      if (qerr.size() == 0) chk(0, "R4 scoreboard empty", 0, 1);
      else begin
        perr = qerr.pop_front();
        ptag = qtag.pop_front();
        chk(flash_hsel == !perr, {ptag, " R5 forward"}, {31'd0, flash_hsel}, {31'd0, !perr});
        pend = 1; pphase = 0;
      end
    end
  end

  task automatic xfer(logic [31:0] a, bit data, bit exp_err, string tag);
    bit ok;
    hsel = 1; htrans = 2'b10; haddr = a; hprot = {3'b001, data};
    qerr.push_back(exp_err); qtag.push_back(tag);
    do begin
      @(negedge clk); ok = hreadyout;
      @(posedge clk); #1;
    end while (!ok);
    hsel = 0; htrans = 2'b00;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_sel = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_sel = 0; reg_write = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    reg_sel = 1; reg_addr = a;
    @(negedge clk);
    chk(reg_rdata == exp, tag, reg_rdata, exp);
    @(posedge clk); #1;
    reg_sel = 0;
  endtask

  task automatic do_reset(logic [31:0] sh);
    hresetn = 0; shadow_word = sh; pend = 0;
    repeat (3) @(posedge clk);
    #1 hresetn = 1; shadow_word = 32'h0;
  endtask

  task automatic drain();
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset(32'hA5A5_0F0F);
    rd(8'h2C, 32'hA5A5_0F0F, "R1 shadow load");
    @(negedge clk);
    chk(hreadyout && !hresp, "R1 idle response", {30'd0, hreadyout, hresp}, 32'd2);
    @(posedge clk); #1;

    wr(8'h28, 32'h1234_5678);
    rd(8'h2C, 32'hA5A5_0F0F, "R2 other offset write ignored");
    rd(8'h28, 32'h0, "R2 other offset reads zero");
    wr(8'h2C, 32'h0);
    rd(8'h2C, 32'h0, "R2 write read back");

    xfer(32'h0000_0100, 0, 1, "R4 fetch seg0 blocked");
    xfer(32'h0000_0100, 1, 0, "R6 data seg0 passes");
    xfer(32'h003C_0000, 0, 1, "R3 fetch seg15 blocked");
    xfer(32'h0040_0000, 0, 0, "R8 outside window passes");
    drain();

    wr(8'h2C, 32'h4000_0020);
    xfer(32'h0014_0000, 0, 0, "R7 fetch seg5 allowed");
    xfer(32'h0018_0000, 0, 1, "R3 fetch seg6 blocked");
    xfer(32'h003C_1234, 0, 0, "R3 fetch seg15 bit30 allowed");
    xfer(32'h0038_0000, 0, 1, "R3 fetch seg14 blocked");
    xfer(32'h0034_0000, 0, 1, "R3 fetch seg13 blocked");
    drain();

    wr(8'h2C, 32'h8FFF_E000);
    xfer(32'h0034_0000, 0, 1, "R9 bits13-27,31 no effect seg13");
    xfer(32'h0000_0000, 0, 1, "R9 bits13-27,31 no effect seg0");
    xfer(32'h0030_0000, 0, 1, "R9 bits13-27,31 no effect seg12");
    drain();

    wr(8'h2C, 32'h1000_0000);
    xfer(32'h0034_0000, 0, 0, "R3 fetch seg13 bit28 allowed");
    xfer(32'h0038_0000, 0, 1, "R3 fetch seg14 bit29 clear");
    drain();

    fork
      wr(8'h2C, 32'hFFFF_FFFF);
      xfer(32'h0000_0000, 0, 1, "R9 same-edge write uses old word");
    join
    xfer(32'h0000_0000, 0, 0, "R9 next phase uses new word");
    drain();

    do_reset(32'hFFFF_FFFF);
    rd(8'h2C, 32'hFFFF_FFFF, "R1 erased shadow");
    xfer(32'h003C_0000, 0, 0, "R1 erased shadow fetch allowed");
    xfer(32'h0008_0000, 0, 0, "R1 erased shadow fetch seg2");
    drain();
    chk(qerr.size() == 0, "R4 scoreboard drained", qerr.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule